// File: doc/BRIEF.md
# Mailbox Command Issue Engine

This block is a bus master that sends a single command to a remote agent through a shared-memory mailbox and collects the reply. A requester hands it a command code, a 4-bit transaction tag, an argument count, an urgent flag and a limit on how many reply words it wants forwarded. The arguments then arrive on a valid/ready stream. The engine builds a 32-bit header word and writes the header and the arguments into the remote 32-entry command ring, starting at the slot the remote side reports as free. It publishes the new write offset and then rings the outbound doorbell.

The engine then polls the inbound doorbell and clears it when it is set. An urgent command gets no reply: the engine drops the urgent request register and reads the acknowledge bit in the status register. A normal command makes the engine read replies from a 16-entry response ring. It skips any reply that carries a different client or tag. For a reply that matches, it returns the reply's error field or drains every data word the reply announces. Two cycle-count limits bound the time spent waiting on a doorbell or on a reply word. At the end the engine gives a one-cycle done pulse with a status code.

Top module: `mbox_cmd_engine`

## Requirements
- R1: The header word carries the command code in bits 10:0, 0 in bit 11, the argument count in bits 22:12, 0 in bit 23, the request tag in bits 27:24 and the CLIENT_ID parameter (default 0xB) in bits 31:28.
- R2: A request with an argument count of 32 or more, or a command code above 2047, ends with status 1 and makes no bus access.
- R3: The first bus access is a read of the free-slot register (word address 0x33). A value of 32 or more ends the command with status 2 and no bus write.
- R4: The header and then each argument are written to command ring words at address 0x00 + offset, with the offset advancing modulo 32. The offset after the last word is then written to the command-valid register (0x30).
- R5: The engine writes 1 to the outbound doorbell (0x38), reads the inbound doorbell (0x39) until bit 0 is set, and then writes 0 to 0x39.
- R6: An urgent command writes 1 to the urgent register (0x32) before the outbound doorbell. After the inbound doorbell is cleared it writes 0 to 0x32 and reads status (0x35). Bit 8 set gives status 0, clear gives status 5. No response register is touched.
- R7: For a normal command the engine reads the response read offset (0x31) and the response write offset (0x34). When they differ it reads the word at 0x20 + read offset, advances the offset modulo 16 and writes it back to 0x31.
- R8: A reply whose bits 31:28 differ from CLIENT_ID or whose bits 27:24 differ from the request tag is discarded, and the engine waits for the inbound doorbell again. A matching reply with a non-zero error field in bits 10:0 ends with status 6, and that field appears on err_code.
- R9: A matching error-free reply makes the engine consume as many data words as its bits 22:12 give, writing back the read offset after each one. Only the first req_keep of them appear on the response stream, and status is 0.
- R10: If the inbound doorbell stays clear past cfg_db_limit cycles, the command ends with status 3. If the response write offset stays unchanged past cfg_poll_limit cycles before a data word, it ends with status 4. Either way the engine returns to idle.
- R11: req_ready is high only in idle when done is low. done is high for exactly one cycle per command. A bus request holds its address, direction and write data until bus_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Engine idle and able to accept |
| req_cmd | input | CMD_W | Command code |
| req_tid | input | 4 | Transaction tag |
| req_argc | input | ARGC_W | Number of argument words |
| req_urgent | input | 1 | Send as urgent command |
| req_keep | input | ARGC_W | Reply data words to forward |
| arg_valid | input | 1 | Argument word valid |
| arg_ready | output | 1 | Engine takes argument word |
| arg_data | input | 32 | Argument word |
| rsp_valid | output | 1 | Forwarded reply word valid |
| rsp_data | output | 32 | Forwarded reply word |
| done | output | 1 | One-cycle completion pulse |
| status | output | 4 | Completion code, valid with done |
| err_code | output | 11 | Reply error field for status 6 |
| cfg_db_limit | input | TMO_W | Doorbell wait limit in cycles |
| cfg_poll_limit | input | TMO_W | Per-word poll limit in cycles |
| bus_req | output | 1 | Single-beat bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 6 | Word address in the mailbox |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete |
| bus_rdata | input | 32 | Read data, valid with bus_ack |

## Verification
A corrupted ring offset becomes visible at the bus port on the next write into a ring or the next offset write-back. It shows as a wrong word address or data value in the write log, so the directed cases start near the top of both rings to force a wrap. A state register stuck in a wrong phase shows up as a write missing from, or added to, the log, such as an urgent clear on a normal command or an offset write-back on an urgent one. It can also show as a wrong status on the done pulse within a few bus beats. A faulty tag or client filter shows as an extra doorbell wait, a wrong final read offset or a wrong count of forwarded words.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int unsigned CMD_DEPTH = 32;
  localparam int unsigned RSP_DEPTH = 16;
  localparam int unsigned CPW       = $clog2(CMD_DEPTH);
  localparam int unsigned RPW       = $clog2(RSP_DEPTH);
  localparam int unsigned ADDR_W    = 6;
  localparam int unsigned CODE_MAX  = 2047;

  localparam logic [ADDR_W-1:0] A_CMD_RING  = 6'h00;
  localparam logic [ADDR_W-1:0] A_RSP_RING  = 6'h20;
  localparam logic [ADDR_W-1:0] A_CMD_VALID = 6'h30;
  localparam logic [ADDR_W-1:0] A_RSP_RD    = 6'h31;
  localparam logic [ADDR_W-1:0] A_URGENT    = 6'h32;
  localparam logic [ADDR_W-1:0] A_CMD_FREE  = 6'h33;
  localparam logic [ADDR_W-1:0] A_RSP_WR    = 6'h34;
  localparam logic [ADDR_W-1:0] A_STATUS    = 6'h35;
  localparam logic [ADDR_W-1:0] A_DB_OUT    = 6'h38;
  localparam logic [ADDR_W-1:0] A_DB_IN     = 6'h39;

  typedef enum logic [3:0] {
    ST_OK       = 4'd0,
    ST_INVAL    = 4'd1,
    ST_NOSPACE  = 4'd2,
    ST_DB_TMO   = 4'd3,
    ST_POLL_TMO = 4'd4,
    ST_NO_UACK  = 4'd5,
    ST_RSP_ERR  = 4'd6
  } mbx_status_e;

  typedef struct packed {
    logic [3:0]  client;
    logic [3:0]  tid;
    logic        rsvd;
    logic [10:0] len;
    logic        ind;
    logic [10:0] code;
  } mbx_hdr_t;

  typedef enum logic [4:0] {
    S_IDLE, S_RD_FREE, S_WR_HDR, S_GET_ARG, S_WR_ARG, S_WR_VALID,
    S_SET_URG, S_RING, S_POLL_DB, S_CLR_DB, S_CLR_URG, S_RD_STAT,
    S_RD_RPTR, S_RD_WPTR, S_RD_HDR, S_WB_HDR, S_POLL_W, S_RD_DATA,
    S_WB_DATA
  } mbx_state_e;

endpackage

// File: rtl/mbox_timer.sv
module mbox_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (en && cnt_q != {W{1'b1}})
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q >= limit);
endmodule

// File: rtl/mbox_hdr.sv
module mbox_hdr
  import mbox_pkg::*;
#(
  parameter logic [3:0] CLIENT_ID = 4'hB
) (
  input  logic [10:0] code,
  input  logic [3:0]  tid,
  input  logic [10:0] len,
  input  logic [31:0] rsp_word,
  output logic [31:0] hdr_word,
  output logic        rsp_match,
  output logic [10:0] rsp_err,
  output logic [10:0] rsp_len
);
  mbx_hdr_t tx, rx;

  always_comb begin
    tx.client = CLIENT_ID;
    tx.tid    = tid;
    tx.rsvd   = 1'b0;
    tx.len    = len;
    tx.ind    = 1'b0;
    tx.code   = code;
  end

  assign hdr_word  = tx;
  assign rx        = rsp_word;
  assign rsp_match = (rx.client == CLIENT_ID) && (rx.tid == tid);
  assign rsp_err   = rx.code;
  assign rsp_len   = rx.len;
endmodule

// File: rtl/mbox_cmd_engine.sv
module mbox_cmd_engine
  import mbox_pkg::*;
#(
  parameter int unsigned CMD_W     = 12,
  parameter int unsigned ARGC_W    = 8,
  parameter int unsigned TMO_W     = 16,
  parameter logic [3:0]  CLIENT_ID = 4'hB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [3:0]        req_tid,
  input  logic [ARGC_W-1:0] req_argc,
  input  logic              req_urgent,
  input  logic [ARGC_W-1:0] req_keep,
  input  logic              arg_valid,
  output logic              arg_ready,
  input  logic [31:0]       arg_data,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              done,
  output logic [3:0]        status,
  output logic [10:0]       err_code,
  input  logic [TMO_W-1:0]  cfg_db_limit,
  input  logic [TMO_W-1:0]  cfg_poll_limit,
  output logic              bus_req,
  output logic              bus_we,
  output logic [5:0]        bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata
);
  mbx_state_e        st_q, st_d;
  logic [10:0]       code_q, code_d;
  logic [3:0]        tid_q, tid_d;
  logic [ARGC_W-1:0] argc_q, argc_d, keep_q, keep_d, cnt_q, cnt_d;
  logic              urg_q, urg_d;
  logic [CPW-1:0]    wptr_q, wptr_d;
  logic [RPW-1:0]    rptr_q, rptr_d;
  logic [10:0]       rem_q, rem_d, err_q, err_d;
  logic [31:0]       word_q, word_d, rdat_q, rdat_d;
  logic              done_q, done_d, rv_q, rv_d;
  logic [3:0]        stat_q, stat_d;

  logic [31:0] hdr_word;
  logic        rsp_match, expired, poll_st;
  logic [10:0] rsp_err, rsp_len;
  logic [CPW-1:0] wptr_inc;
  logic [RPW-1:0] rptr_inc;

  mbox_hdr #(.CLIENT_ID(CLIENT_ID)) u_hdr (
    .code(code_q), .tid(tid_q), .len(11'(argc_q)), .rsp_word(word_q),
    .hdr_word(hdr_word), .rsp_match(rsp_match), .rsp_err(rsp_err),
    .rsp_len(rsp_len)
  );

  assign poll_st = (st_q == S_POLL_DB) || (st_q == S_POLL_W);

  mbox_timer #(.W(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(!poll_st), .en(poll_st),
    .limit((st_q == S_POLL_W) ? cfg_poll_limit : cfg_db_limit),
    .expired(expired)
  );

  assign wptr_inc = (wptr_q == CPW'(CMD_DEPTH - 1)) ? '0 : wptr_q + 1'b1;
  assign rptr_inc = (rptr_q == RPW'(RSP_DEPTH - 1)) ? '0 : rptr_q + 1'b1;

  // bus command decode
  always_comb begin
    bus_req   = !(st_q == S_IDLE || st_q == S_GET_ARG);
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    unique case (st_q)
      S_RD_FREE:  bus_addr = A_CMD_FREE;
      S_WR_HDR:   begin bus_we = 1'b1; bus_addr = A_CMD_RING + 6'(wptr_q); bus_wdata = hdr_word; end
      S_WR_ARG:   begin bus_we = 1'b1; bus_addr = A_CMD_RING + 6'(wptr_q); bus_wdata = word_q; end
      S_WR_VALID: begin bus_we = 1'b1; bus_addr = A_CMD_VALID; bus_wdata = 32'(wptr_q); end
      S_SET_URG:  begin bus_we = 1'b1; bus_addr = A_URGENT; bus_wdata = 32'd1; end
      S_RING:     begin bus_we = 1'b1; bus_addr = A_DB_OUT; bus_wdata = 32'd1; end
      S_POLL_DB:  bus_addr = A_DB_IN;
      S_CLR_DB:   begin bus_we = 1'b1; bus_addr = A_DB_IN; end
      S_CLR_URG:  begin bus_we = 1'b1; bus_addr = A_URGENT; end
      S_RD_STAT:  bus_addr = A_STATUS;
      S_RD_RPTR:  bus_addr = A_RSP_RD;
      S_RD_WPTR,
      S_POLL_W:   bus_addr = A_RSP_WR;
      S_RD_HDR,
      S_RD_DATA:  bus_addr = A_RSP_RING + 6'(rptr_q);
      S_WB_HDR,
      S_WB_DATA:  begin bus_we = 1'b1; bus_addr = A_RSP_RD; bus_wdata = 32'(rptr_q); end
      default:    ;
    endcase
  end

  // next-state logic
  always_comb begin
    st_d = st_q;   code_d = code_q; tid_d = tid_q;   argc_d = argc_q;
    keep_d = keep_q; cnt_d = cnt_q; urg_d = urg_q;   wptr_d = wptr_q;
    rptr_d = rptr_q; rem_d = rem_q; err_d = err_q;   word_d = word_q;
    rdat_d = rdat_q; stat_d = stat_q;
    done_d = 1'b0; rv_d = 1'b0;

    unique case (st_q)
      S_IDLE: if (req_valid && !done_q) begin
        code_d = req_cmd[10:0]; tid_d = req_tid; argc_d = req_argc;
        keep_d = req_keep; urg_d = req_urgent; err_d = '0;
        if (req_argc >= ARGC_W'(CMD_DEPTH) || req_cmd > CMD_W'(CODE_MAX)) begin
          done_d = 1'b1; stat_d = ST_INVAL;
        end else begin
          st_d = S_RD_FREE;
        end
      end
      S_RD_FREE: if (bus_ack) begin
        if (bus_rdata >= 32'(CMD_DEPTH)) begin
          st_d = S_IDLE; done_d = 1'b1; stat_d = ST_NOSPACE;
        end else begin
          wptr_d = bus_rdata[CPW-1:0]; st_d = S_WR_HDR;
        end
      end
      S_WR_HDR: if (bus_ack) begin
        wptr_d = wptr_inc; cnt_d = '0;
        st_d = (argc_q == '0) ? S_WR_VALID : S_GET_ARG;
      end
      S_GET_ARG: if (arg_valid) begin
        word_d = arg_data; st_d = S_WR_ARG;
      end
      S_WR_ARG: if (bus_ack) begin
        wptr_d = wptr_inc; cnt_d = cnt_q + 1'b1;
        st_d = (cnt_q + 1'b1 == argc_q) ? S_WR_VALID : S_GET_ARG;
      end
      S_WR_VALID: if (bus_ack) st_d = urg_q ? S_SET_URG : S_RING;
      S_SET_URG:  if (bus_ack) st_d = S_RING;
      S_RING:     if (bus_ack) st_d = S_POLL_DB;
      S_POLL_DB: if (bus_ack) begin
        if (bus_rdata[0]) st_d = S_CLR_DB;
        else if (expired) begin
          st_d = S_IDLE; done_d = 1'b1; stat_d = ST_DB_TMO;
        end
      end
      S_CLR_DB:  if (bus_ack) st_d = urg_q ? S_CLR_URG : S_RD_RPTR;
      S_CLR_URG: if (bus_ack) st_d = S_RD_STAT;
      S_RD_STAT: if (bus_ack) begin
        st_d = S_IDLE; done_d = 1'b1;
        stat_d = bus_rdata[8] ? ST_OK : ST_NO_UACK;
      end
      S_RD_RPTR: if (bus_ack) begin
        rptr_d = bus_rdata[RPW-1:0]; st_d = S_RD_WPTR;
      end
      S_RD_WPTR: if (bus_ack)
        st_d = (bus_rdata[RPW-1:0] != rptr_q) ? S_RD_HDR : S_POLL_DB;
      S_RD_HDR: if (bus_ack) begin
        word_d = bus_rdata; rptr_d = rptr_inc; st_d = S_WB_HDR;
      end
      S_WB_HDR: if (bus_ack) begin
        if (!rsp_match) st_d = S_POLL_DB;
        else if (rsp_err != '0) begin
          st_d = S_IDLE; done_d = 1'b1; stat_d = ST_RSP_ERR; err_d = rsp_err;
        end else if (rsp_len == '0) begin
          st_d = S_IDLE; done_d = 1'b1; stat_d = ST_OK;
        end else begin
          rem_d = rsp_len; cnt_d = '0; st_d = S_POLL_W;
        end
      end
      S_POLL_W: if (bus_ack) begin
        if (bus_rdata[RPW-1:0] != rptr_q) st_d = S_RD_DATA;
        else if (expired) begin
          st_d = S_IDLE; done_d = 1'b1; stat_d = ST_POLL_TMO;
        end
      end
      S_RD_DATA: if (bus_ack) begin
        rptr_d = rptr_inc; rem_d = rem_q - 1'b1; st_d = S_WB_DATA;
        if (cnt_q < keep_q) begin
          rv_d = 1'b1; rdat_d = bus_rdata; cnt_d = cnt_q + 1'b1;
        end
      end
      S_WB_DATA: if (bus_ack) begin
        if (rem_q == '0) begin
          st_d = S_IDLE; done_d = 1'b1; stat_d = ST_OK;
        end else st_d = S_POLL_W;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; code_q <= '0; tid_q <= '0; argc_q <= '0; keep_q <= '0;
      cnt_q <= '0; urg_q <= 1'b0; wptr_q <= '0; rptr_q <= '0; rem_q <= '0;
      err_q <= '0; word_q <= '0; rdat_q <= '0; stat_q <= '0;
      done_q <= 1'b0; rv_q <= 1'b0;
    end else begin
      st_q <= st_d; code_q <= code_d; tid_q <= tid_d; argc_q <= argc_d;
      keep_q <= keep_d; cnt_q <= cnt_d; urg_q <= urg_d; wptr_q <= wptr_d;
      rptr_q <= rptr_d; rem_q <= rem_d; err_q <= err_d; word_q <= word_d;
      rdat_q <= rdat_d; stat_q <= stat_d; done_q <= done_d; rv_q <= rv_d;
    end
  end

  assign req_ready = (st_q == S_IDLE) && !done_q;
  assign arg_ready = (st_q == S_GET_ARG);
  assign rsp_valid = rv_q;
  assign rsp_data  = rdat_q;
  assign done      = done_q;
  assign status    = stat_q;
  assign err_code  = err_q;
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        arg_ready,
  input logic        rsp_valid,
  input logic        done,
  input logic [3:0]  status,
  input logic [10:0] err_code,
  input logic        bus_req,
  input logic        bus_we,
  input logic [5:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_ack
);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_bus_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_req && !arg_ready && !rsp_valid);

  assert_arg_no_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arg_ready |-> !bus_req);

  assert_status_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status <= 4'd6);

  assert_err_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == 4'd6 |-> err_code != 11'd0);

  assert_rsp_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready && !done);
endmodule

bind mbox_cmd_engine mbox_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .arg_ready(arg_ready),
  .rsp_valid(rsp_valid), .done(done), .status(status), .err_code(err_code),
  .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/sim_mbox_cmd_engine.sv
module sim_mbox_cmd_engine;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        req_valid = 1'b0, req_urgent = 1'b0;
  logic [11:0] req_cmd = '0;
  logic [3:0]  req_tid = '0;
  logic [7:0]  req_argc = '0, req_keep = '0;
  logic        req_ready, arg_ready, arg_valid, rsp_valid, done;
  logic [31:0] arg_data, rsp_data, bus_wdata, bus_rdata;
  logic [3:0]  status;
  logic [10:0] err_code;
  logic [15:0] cfg_db_limit = 16'd40, cfg_poll_limit = 16'd40;
  logic        bus_req, bus_we, bus_ack;
  logic [5:0]  bus_addr;

  mbox_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_tid(req_tid), .req_argc(req_argc),
    .req_urgent(req_urgent), .req_keep(req_keep), .arg_valid(arg_valid),
    .arg_ready(arg_ready), .arg_data(arg_data), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .done(done), .status(status), .err_code(err_code),
    .cfg_db_limit(cfg_db_limit), .cfg_poll_limit(cfg_poll_limit),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  int checks = 0, failures = 0;

  // mailbox memory model with write log
  logic [31:0] mem [64];
  logic [5:0]  wa [64];
  logic [31:0] wd [64];
  int wn = 0, rn_bus = 0, rearm = 0;
  logic ack_q = 1'b0;
  logic [31:0] rd_q = '0;
  assign bus_ack = ack_q;
  assign bus_rdata = rd_q;

  always @(posedge clk) begin
    if (!rst_n) ack_q <= 1'b0;
    else if (bus_req && !ack_q) begin
      ack_q <= 1'b1;
      if (bus_we) begin
        if (wn < 64) begin wa[wn] = bus_addr; wd[wn] = bus_wdata; end
        wn = wn + 1;
        if (bus_addr == 6'h39 && bus_wdata == 0 && rearm > 0) rearm = rearm - 1;
        else mem[bus_addr] = bus_wdata;
      end else begin
        rn_bus = rn_bus + 1;
        rd_q <= mem[bus_addr];
      end
    end else ack_q <= 1'b0;
  end

  // argument feeder and response capture
  logic [31:0] arg_q [8];
  int arg_n = 0, aidx = 0;
  assign arg_valid = (aidx < arg_n);
  assign arg_data  = arg_q[aidx[2:0]];
  always @(posedge clk) if (arg_valid && arg_ready) aidx = aidx + 1;

  logic [31:0] rsp_q [8];
  int rn = 0;
  always @(posedge clk) if (rsp_valid) begin
    if (rn < 8) rsp_q[rn] = rsp_data;
    rn = rn + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_is(input int i, input logic [5:0] a, input logic [31:0] d, input string req);
    chk(wa[i] == a, req, 32'(wa[i]), 32'(a));
    chk(wd[i] == d, req, wd[i], d);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = '0;
    wn = 0; rn_bus = 0; rn = 0; aidx = 0; arg_n = 0; rearm = 0;
  endtask

  logic [3:0] got_st;
  task automatic run(input logic [11:0] cmd, input logic [3:0] tid, input logic [7:0] argc,
                     input bit urg, input logic [7:0] keep, input int nargs);
    int guard;
    @(negedge clk);
    arg_n = nargs;
    req_cmd = cmd; req_tid = tid; req_argc = argc; req_urgent = urg; req_keep = keep;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    chk(guard < 5000, "R11 done seen", 32'(guard), 0);
    got_st = status;
    @(negedge clk);
    chk(!done, "R11 done single cycle", 32'(done), 0);
    chk(req_ready, "R11 ready after done", 32'(req_ready), 1);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R11 reset ready", 32'(req_ready), 1);
    chk(!done && !bus_req && !rsp_valid, "R11 reset outputs", {29'd0, done, bus_req, rsp_valid}, 0);
  endtask

  task automatic t_invalid();
    clear_mem();
    run(12'h010, 4'h1, 8'd32, 1'b0, 8'd0, 0);
    chk(got_st == 4'd1, "R2 argc 32 status", 32'(got_st), 1);
    chk(wn == 0 && rn_bus == 0, "R2 no bus access", 32'(wn + rn_bus), 0);
    run(12'h800, 4'h1, 8'd0, 1'b0, 8'd0, 0);
    chk(got_st == 4'd1, "R2 code 2048 status", 32'(got_st), 1);
    chk(wn == 0 && rn_bus == 0, "R2 no bus access code", 32'(wn + rn_bus), 0);
  endtask

  task automatic t_nospace();
    clear_mem();
    mem[6'h33] = 32;
    run(12'h020, 4'h2, 8'd0, 1'b0, 8'd0, 0);
    chk(got_st == 4'd2, "R3 status", 32'(got_st), 2);
    chk(wn == 0, "R3 no writes", 32'(wn), 0);
    chk(rn_bus == 1, "R3 single read", 32'(rn_bus), 1);
  endtask

  task automatic t_normal();
    clear_mem();
    mem[6'h33] = 30; mem[6'h31] = 5; mem[6'h34] = 8; mem[6'h39] = 1;
    mem[6'h25] = 32'hB500_2000; mem[6'h26] = 32'hAAAA_0001; mem[6'h27] = 32'hAAAA_0002;
    arg_q[0] = 32'h1111_0000; arg_q[1] = 32'h2222_0000; arg_q[2] = 32'h3333_0000;
    run(12'h123, 4'h5, 8'd3, 1'b0, 8'd1, 3);
    chk(got_st == 4'd0, "R9 status ok", 32'(got_st), 0);
    chk(wn == 10, "R4 write count", 32'(wn), 10);
    wr_is(0, 6'h1E, 32'hB500_3123, "R1 header");
    wr_is(1, 6'h1F, 32'h1111_0000, "R4 arg0");
    wr_is(2, 6'h00, 32'h2222_0000, "R4 arg1 wrap");
    wr_is(3, 6'h01, 32'h3333_0000, "R4 arg2");
    wr_is(4, 6'h30, 32'd2, "R4 valid offset");
    wr_is(5, 6'h38, 32'd1, "R5 doorbell out");
    wr_is(6, 6'h39, 32'd0, "R5 doorbell clear");
    wr_is(7, 6'h31, 32'd6, "R7 read offset hdr");
    wr_is(9, 6'h31, 32'd8, "R9 read offset last");
    chk(rn == 1, "R9 forwarded count", 32'(rn), 1);
    chk(rsp_q[0] == 32'hAAAA_0001, "R9 forwarded word", rsp_q[0], 32'hAAAA_0001);
  endtask

  task automatic t_resp_wrap();
    clear_mem();
    mem[6'h33] = 0; mem[6'h31] = 15; mem[6'h34] = 2; mem[6'h39] = 1;
    mem[6'h2F] = 32'hBA00_2000; mem[6'h20] = 32'd101; mem[6'h21] = 32'd102;
    run(12'h7FF, 4'hA, 8'd0, 1'b0, 8'd5, 0);
    chk(got_st == 4'd0, "R7 status", 32'(got_st), 0);
    wr_is(0, 6'h00, 32'hBA00_07FF, "R1 header max code");
    wr_is(1, 6'h30, 32'd1, "R4 valid offset");
    wr_is(4, 6'h31, 32'd0, "R7 offset wrap");
    wr_is(6, 6'h31, 32'd2, "R7 offset final");
    chk(rn == 2, "R9 all words forwarded", 32'(rn), 2);
    chk(rsp_q[1] == 32'd102, "R9 second word", rsp_q[1], 32'd102);
  endtask

  task automatic t_urgent();
    clear_mem();
    mem[6'h33] = 4; mem[6'h39] = 1; mem[6'h35] = 32'h100;
    arg_q[0] = 32'hCAFE_0001;
    run(12'h002, 4'h1, 8'd1, 1'b1, 8'd0, 1);
    chk(got_st == 4'd0, "R6 ack status", 32'(got_st), 0);
    chk(wn == 7, "R6 write count", 32'(wn), 7);
    wr_is(0, 6'h04, 32'hB100_1002, "R1 urgent header");
    wr_is(3, 6'h32, 32'd1, "R6 urgent set");
    wr_is(4, 6'h38, 32'd1, "R6 doorbell after urgent");
    wr_is(6, 6'h32, 32'd0, "R6 urgent clear");
    clear_mem();
    mem[6'h33] = 4; mem[6'h39] = 1; mem[6'h35] = 32'h0FF;
    run(12'h002, 4'h1, 8'd0, 1'b1, 8'd0, 0);
    chk(got_st == 4'd5, "R6 no ack status", 32'(got_st), 5);
  endtask

  task automatic t_resp_err();
    clear_mem();
    mem[6'h34] = 1; mem[6'h39] = 1; mem[6'h20] = 32'hB300_0003;
    run(12'h010, 4'h3, 8'd0, 1'b0, 8'd0, 0);
    chk(got_st == 4'd6, "R8 error status", 32'(got_st), 6);
    chk(err_code == 11'd3, "R8 error code", 32'(err_code), 3);
    chk(mem[6'h31] == 1, "R7 offset written back", mem[6'h31], 1);
  endtask

  task automatic t_mismatch();
    clear_mem();
    mem[6'h34] = 3; mem[6'h39] = 1; rearm = 2;
    mem[6'h20] = 32'hB800_0000; mem[6'h21] = 32'h3700_0000; mem[6'h22] = 32'hB700_0000;
    run(12'h011, 4'h7, 8'd0, 1'b0, 8'd4, 0);
    chk(got_st == 4'd0, "R8 match after skips", 32'(got_st), 0);
    chk(mem[6'h31] == 3, "R8 all three read", mem[6'h31], 3);
    chk(rn == 0, "R8 nothing forwarded", 32'(rn), 0);
  endtask

  task automatic t_db_timeout();
    clear_mem();
    run(12'h012, 4'h4, 8'd0, 1'b0, 8'd0, 0);
    chk(got_st == 4'd3, "R10 doorbell timeout", 32'(got_st), 3);
    chk(wn == 3 && wa[2] == 6'h38, "R10 last write doorbell", 32'(wn), 3);
  endtask

  task automatic t_poll_timeout();
    clear_mem();
    mem[6'h34] = 1; mem[6'h39] = 1; mem[6'h20] = 32'hB400_2000;
    run(12'h013, 4'h4, 8'd0, 1'b0, 8'd0, 0);
    chk(got_st == 4'd4, "R10 poll timeout", 32'(got_st), 4);
    chk(mem[6'h31] == 1, "R10 offset after header", mem[6'h31], 1);
    chk(rn == 0, "R9 keep zero none forwarded", 32'(rn), 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_invalid();
    t_nospace();
    t_normal();
    t_resp_wrap();
    t_urgent();
    t_resp_err();
    t_mismatch();
    t_db_timeout();
    t_poll_timeout();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule